// File: doc/BRIEF.md
# Two-Thirds Rate Clock Pulse Gate

This block derives a clock whose average rate is two thirds of its input clock, for instance about 33.3 MHz from a 50 MHz source. It keeps two input pulses and blanks the third, in a repeating pattern. A three-state phase counter moves on each falling edge of the input clock. Its upper bit masks the input clock through a single AND gate.

The output is not a uniform clock. Each pulse it passes is exactly as wide as an input high phase. After every second pulse there is a longer low gap where a pulse was removed. Logic that depends on a 50% duty cycle or an even period must not use it. The phase counter is brought out on its own port so that the position in the pattern can be observed.

Top module: `clk_two_thirds_gen`

## Requirements
- R1: Over a window of 300 input clock cycles that starts at a reset release, `clk_out` shows exactly 200 rising edges.
- R2: `phase` only ever holds 0, 1 or 2 and never holds 3.
- R3: `phase` changes only on a falling edge of `clk_in`, stepping 0 to 1, 1 to 2 and 2 back to 0.
- R4: While `phase` is 2 (bit 1 set), `clk_out` stays low for the whole input high phase.
- R5: While `phase` is 0 or 1, `clk_out` follows `clk_in`, so every output pulse is exactly as wide as an input high phase.
- R6: Driving `rst_n` low forces `phase` to 0 at once, without waiting for a clock edge, and holds it there. The first input high phase after reset is passed to `clk_out`.
- R7: `clk_out` is low whenever `clk_in` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_out | output | 1 | Gated clock: two of every three source pulses |
| phase | output | 2 | Current phase counter value (0, 1 or 2) |

## Verification
The checks assume that `clk_in` toggles freely with a steady period. They also assume that `rst_n` changes only while `clk_in` is low, so that a reset edge never cuts an input pulse short. The bench keeps within both assumptions. It drives a fixed 250 MHz clock and moves `rst_n` only at the middle of a low phase. The mid-run reset is taken at a point where the counter holds a nonzero phase, so that the asynchronous clear can be seen.

// File: rtl/clk_two_thirds_gen.sv
module clk_two_thirds_gen (
  input  logic       clk_in,
  input  logic       rst_n,
  output logic       clk_out,
  output logic [1:0] phase
);
  localparam logic [1:0] LAST = 2'd2;

  logic [1:0] cnt_q;

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n)             cnt_q <= 2'd0;
    else if (cnt_q == LAST) cnt_q <= 2'd0;
    else                    cnt_q <= cnt_q + 2'd1;
  end

  assign clk_out = clk_in & ~cnt_q[1];
  assign phase   = cnt_q;
endmodule

module clk_two_thirds_gen_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic       clk_out,
  input logic [1:0] phase
);
  // R2
  no_phase3_chk: assert property (@(posedge clk_in) disable iff (!rst_n) phase != 2'd3);

  // R3
  wrap_chk: assert property (@(negedge clk_in) disable iff (!rst_n) phase == 2'd2 |=> phase == 2'd0);

  // R3
  step_chk: assert property (@(negedge clk_in) disable iff (!rst_n) phase == 2'd0 |=> phase == 2'd1);

  // R4
  mask_chk: assert property (@(negedge clk_in) disable iff (!rst_n) phase == 2'd2 |-> !clk_out);

  // R5
  pass_chk: assert property (@(negedge clk_in) disable iff (!rst_n) phase != 2'd2 |-> clk_out);

  // R6
  reset_chk: assert property (@(posedge clk_in) !rst_n |-> phase == 2'd0);

  // R7
  low_chk: assert property (@(posedge clk_in) disable iff (!rst_n) !clk_out);
endmodule

bind clk_two_thirds_gen clk_two_thirds_gen_chk u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .clk_out (clk_out),
  .phase   (phase)
);

// File: tb/clk_two_thirds_gen_bench.sv
`timescale 1ns/1ps
module clk_two_thirds_gen_bench;
  logic       clk_in;
  logic       rst_n;
  logic       clk_out;
  logic [1:0] phase;

  int  checks = 0;
  int  errors = 0;
  int  rises  = 0;
  bit  cnt_en = 0;
  real t_rise = 0.0;
  real min_w  = 1000.0;

  clk_two_thirds_gen u_clk_two_thirds_gen (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .clk_out (clk_out),
    .phase   (phase)
  );

  initial clk_in = 1'b0;
  always #2 clk_in = ~clk_in;

  always @(posedge clk_out) begin
    t_rise = $realtime;
    if (cnt_en) rises++;
  end

  always @(negedge clk_out) begin
    if (cnt_en && ($realtime - t_rise) < min_w) min_w = $realtime - t_rise;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_in); #1;
      check(phase == 2'(i % 3), {tag, " R3 phase high"}, phase, i % 3);
      check(phase != 2'd3, "R2 phase range", phase, 0);
      if (i % 3 == 2) check(clk_out == 1'b0, "R4 masked pulse", clk_out, 0);
      else            check(clk_out == 1'b1, "R5 passed pulse", clk_out, 1);
      #2;
      check(clk_out == 1'b0, "R7 low phase", clk_out, 0);
      check(phase == 2'((i + 1) % 3), {tag, " R3 phase low"}, phase, (i + 1) % 3);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    @(posedge clk_in); #1;
    check(phase == 2'd0, "R6 reset phase", phase, 0);
    check(clk_out == 1'b1, "R6 pass in reset", clk_out, 1);
    @(negedge clk_in); #1;
    check(phase == 2'd0, "R6 reset hold", phase, 0);
    rst_n = 1'b1;
    cnt_en = 1'b1;
    run_cycles(300, "window");
    cnt_en = 1'b0;
    check(rises == 200, "R1 rising edges", rises, 200);
    check(min_w > 1.999 && min_w < 2.001, "R5 pulse width ps", int'(min_w * 1000.0), 2000);
    // now mid-low with phase 0; step to phase 1 and reset asynchronously
    @(posedge clk_in); #3;
    check(phase == 2'd1, "R3 pre-reset phase", phase, 1);
    rst_n = 1'b0;
    #0.2;
    check(phase == 2'd0, "R6 async clear", phase, 0);
    @(posedge clk_in); #1;
    check(clk_out == 1'b1, "R6 pass during reset", clk_out, 1);
    #2;
    check(phase == 2'd0, "R6 hold over edge", phase, 0);
    rst_n = 1'b1;
    run_cycles(9, "restart R6");
    finish_run();
  end
endmodule